// File: doc/BRIEF.md
# Engine Handle Binding Table

This block holds a small set of handle registers. Each one can be tied to one resource out of a fixed pool of hardware engines. Every resource in the pool carries a type code that is fixed at build time. Software issues one command at a time on a single command port. The commands are:

- acquire a free resource of a given type;
- release a handle;
- export a handle's binding as a 32-bit word;
- rebind a handle from such a word;
- issue an engine command through a handle.

Every command gets a registered response carrying a data word, a fault flag and a flag that marks software bindings.

An exported hardware binding is the resource index shifted left by one, so bit 0 is always clear. A word with bit 0 set stands for an engine that software emulates. Such a word is stored as it is, and any engine command on that handle faults so that a trap handler can take over. A rebind with bit 0 clear is checked against the real pool before it is accepted. A per-resource busy vector shows which engines are owned.

Top module: `eng_bind_table`

## Requirements
- R1: After reset, every handle is unbound, `res_busy` is all zero and `rsp_valid` is low.
- R2: Every command accepted with `cmd_valid` high produces `rsp_valid` high exactly one cycle later, and `rsp_valid` is low otherwise. Operation codes are 0 no-op, 1 acquire, 2 release, 3 export, 4 rebind and 5 engine command. A no-op answers without fault, and codes 6 and 7 fault. `rsp_data` is zero whenever `rsp_fault` is set. `rsp_sw` is high when the addressed handle holds a software binding after the command.
- R3: Acquire on an unbound handle binds the lowest-indexed free resource whose type equals `cmd_type`. It returns that index shifted left by one and sets its busy bit. The default resource types, from index 0 to 7, are 0,0,1,1,1,2,3,3.
- R4: Acquire faults when no free resource of the requested type exists, and the table is left unchanged.
- R5: Release of a hardware binding frees its resource. Release of a software binding unbinds the handle without fault. Release of an unbound handle faults.
- R6: Export of a hardware binding returns the resource index shifted left by one, with bit 0 clear. Export of a software binding returns the stored word with `rsp_sw` set. Export of an unbound handle faults.
- R7: Rebind with bit 0 clear takes bits 31:1 as a resource index. It faults if that index is not below the pool size, if the resource type differs from `cmd_type`, or if the resource is busy. Otherwise it binds the resource and echoes the word.
- R8: Rebind with bit 0 set stores the word as a software binding, echoes it with `rsp_sw` set and leaves `res_busy` unchanged.
- R9: An engine command on a hardware-bound handle returns the binding word without fault. On a software-bound handle it faults with `rsp_sw` set. On an unbound handle it faults with `rsp_sw` clear.
- R10: Acquire or rebind on a handle that is already bound faults and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_handle | input | clog2(N_HANDLE) | Addressed handle |
| cmd_type | input | TYPE_W | Requested resource type |
| cmd_data | input | 32 | Binding word for rebind |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Binding word or zero |
| rsp_fault | output | 1 | Command failed |
| rsp_sw | output | 1 | Handle holds a software binding |
| res_busy | output | N_RESOURCE | Per-resource owned flag |

## Verification
A command driven before a rising edge is captured at that edge. Its whole response (`rsp_valid`, data, fault, software flag) is then registered and due one cycle later. The effect of the command on `res_busy` shows up in the same cycle as the response, because the busy vector is decoded straight from the table registers. The bench drives each command at a falling edge and samples all outputs at the next falling edge, which is half a cycle after the capturing edge. A reference model in the bench predicts response and busy vector for that same cycle.

// File: rtl/eng_bind_pkg.sv
package eng_bind_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACQ = 3'd1,
      OP_REL = 3'd2,
      OP_EXP = 3'd3,
      OP_REB = 3'd4,
      OP_CMD = 3'd5
   } bind_op_e;
endpackage

// File: rtl/eng_bind_busy.sv
module eng_bind_busy #(
   parameter int N_HANDLE   = 4,
   parameter int N_RESOURCE = 8,
   parameter int RIDX_W     = 3
) (
   input  logic [N_HANDLE-1:0]        hw_bound,
   input  logic [N_HANDLE*RIDX_W-1:0] hw_idx,
   output logic [N_RESOURCE-1:0]      busy
);
   for (genvar r = 0; r < N_RESOURCE; r++) begin : g_res
      always_comb begin
         busy[r] = 1'b0;
         for (int h = 0; h < N_HANDLE; h++) begin
            if (hw_bound[h] && hw_idx[h*RIDX_W +: RIDX_W] == RIDX_W'(r))
               busy[r] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/eng_bind_pick.sv
module eng_bind_pick #(
   parameter int N_RESOURCE = 8,
   parameter int TYPE_W     = 4,
   parameter int RIDX_W     = 3,
   parameter logic [N_RESOURCE*TYPE_W-1:0] RES_TYPE = '0
) (
   input  logic [N_RESOURCE-1:0] busy,
   input  logic [TYPE_W-1:0]     want_type,
   output logic                  found,
   output logic [RIDX_W-1:0]     idx
);
   logic [N_RESOURCE-1:0] match;

   for (genvar r = 0; r < N_RESOURCE; r++) begin : g_match
      assign match[r] = !busy[r] && (RES_TYPE[r*TYPE_W +: TYPE_W] == want_type);
   end

   always_comb begin
      idx = '0;
      for (int r = N_RESOURCE - 1; r >= 0; r--) begin
         if (match[r]) idx = RIDX_W'(r);
      end
   end

   assign found = |match;
endmodule

// File: rtl/eng_bind_table.sv
module eng_bind_table
   import eng_bind_pkg::*;
#(
   parameter int N_HANDLE   = 4,
   parameter int N_RESOURCE = 8,
   parameter int TYPE_W     = 4,
   parameter logic [N_RESOURCE*TYPE_W-1:0] RES_TYPE = 32'h3321_1100,
   localparam int HIDX_W = (N_HANDLE > 1) ? $clog2(N_HANDLE) : 1,
   localparam int RIDX_W = (N_RESOURCE > 1) ? $clog2(N_RESOURCE) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [2:0]            cmd_op,
   input  logic [HIDX_W-1:0]     cmd_handle,
   input  logic [TYPE_W-1:0]     cmd_type,
   input  logic [WORD_W-1:0]     cmd_data,
   output logic                  rsp_valid,
   output logic [WORD_W-1:0]     rsp_data,
   output logic                  rsp_fault,
   output logic                  rsp_sw,
   output logic [N_RESOURCE-1:0] res_busy
);
   if (N_HANDLE < 2 || (1 << HIDX_W) != N_HANDLE) begin : g_chk_h
      $error("N_HANDLE must be a power of two, at least 2");
   end
   if (N_RESOURCE < 1 || RIDX_W > WORD_W - 2) begin : g_chk_r
      $error("N_RESOURCE out of range");
   end
   if (TYPE_W < 1) begin : g_chk_t
      $error("TYPE_W must be positive");
   end

   logic [N_HANDLE-1:0]        h_bound, h_sw;
   logic [WORD_W-1:0]          h_word [N_HANDLE];
   logic [N_HANDLE*RIDX_W-1:0] h_idx_flat;
   logic [N_HANDLE-1:0]        h_hw;

   for (genvar h = 0; h < N_HANDLE; h++) begin : g_flat
      assign h_idx_flat[h*RIDX_W +: RIDX_W] = h_word[h][RIDX_W:1];
      assign h_hw[h] = h_bound[h] && !h_sw[h];
   end

   eng_bind_busy #(
      .N_HANDLE(N_HANDLE), .N_RESOURCE(N_RESOURCE), .RIDX_W(RIDX_W)
   ) u_busy (
      .hw_bound(h_hw), .hw_idx(h_idx_flat), .busy(res_busy)
   );

   logic              pick_found;
   logic [RIDX_W-1:0] pick_idx;

   eng_bind_pick #(
      .N_RESOURCE(N_RESOURCE), .TYPE_W(TYPE_W), .RIDX_W(RIDX_W), .RES_TYPE(RES_TYPE)
   ) u_pick (
      .busy(res_busy), .want_type(cmd_type), .found(pick_found), .idx(pick_idx)
   );

   // rebind validation against the real pool
   logic [WORD_W-2:0] reb_full_idx;
   logic              reb_in_range, reb_type_ok, reb_free;
   assign reb_full_idx = cmd_data[WORD_W-1:1];
   assign reb_in_range = reb_full_idx < (WORD_W-1)'(N_RESOURCE);

   always_comb begin
      reb_type_ok = 1'b0;
      reb_free    = 1'b0;
      for (int r = 0; r < N_RESOURCE; r++) begin
         if (reb_full_idx == (WORD_W-1)'(r)) begin
            reb_type_ok = RES_TYPE[r*TYPE_W +: TYPE_W] == cmd_type;
            reb_free    = !res_busy[r];
         end
      end
   end

   logic              sel_bound, sel_sw;
   logic [WORD_W-1:0] sel_word;
   assign sel_bound = h_bound[cmd_handle];
   assign sel_sw    = h_sw[cmd_handle];
   assign sel_word  = h_word[cmd_handle];

   logic              nx_fault, wr_bind, wr_clear, wr_sw;
   logic [WORD_W-1:0] nx_data, wr_word;

   always_comb begin
      nx_fault = 1'b0;
      nx_data  = '0;
      wr_bind  = 1'b0;
      wr_clear = 1'b0;
      wr_sw    = 1'b0;
      wr_word  = '0;
      case (cmd_op)
         OP_NOP: ;
         OP_ACQ: begin
            nx_fault = sel_bound || !pick_found;
            wr_word  = WORD_W'({pick_idx, 1'b0});
            wr_bind  = !nx_fault;
            nx_data  = wr_word;
         end
         OP_REL: begin
            nx_fault = !sel_bound;
            wr_clear = sel_bound;
         end
         OP_EXP: begin
            nx_fault = !sel_bound;
            nx_data  = sel_word;
         end
         OP_REB: begin
            wr_sw    = cmd_data[0];
            nx_fault = sel_bound ||
                       (!cmd_data[0] && !(reb_in_range && reb_type_ok && reb_free));
            wr_word  = cmd_data;
            wr_bind  = !nx_fault;
            nx_data  = cmd_data;
         end
         OP_CMD: begin
            nx_fault = !sel_bound || sel_sw;
            nx_data  = sel_word;
         end
         default: nx_fault = 1'b1;
      endcase
      if (nx_fault) nx_data = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_bound   <= '0;
         h_sw      <= '0;
         for (int h = 0; h < N_HANDLE; h++) h_word[h] <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_fault <= 1'b0;
         rsp_sw    <= 1'b0;
      end else begin
         rsp_valid <= cmd_valid;
         if (cmd_valid) begin
            rsp_data  <= nx_data;
            rsp_fault <= nx_fault;
            if (wr_bind) begin
               h_bound[cmd_handle] <= 1'b1;
               h_sw[cmd_handle]    <= wr_sw;
               h_word[cmd_handle]  <= wr_word;
               rsp_sw              <= wr_sw;
            end else if (wr_clear) begin
               h_bound[cmd_handle] <= 1'b0;
               h_sw[cmd_handle]    <= 1'b0;
               h_word[cmd_handle]  <= '0;
               rsp_sw              <= 1'b0;
            end else begin
               rsp_sw <= sel_bound && sel_sw;
            end
         end
      end
   end
endmodule

// File: rtl/eng_bind_table_chk.sv
module eng_bind_table_chk
   import eng_bind_pkg::*;
#(
   parameter int N_HANDLE   = 4,
   parameter int N_RESOURCE = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_valid,
   input logic [2:0]            cmd_op,
   input logic                  rsp_valid,
   input logic [WORD_W-1:0]     rsp_data,
   input logic                  rsp_fault,
   input logic                  rsp_sw,
   input logic [N_RESOURCE-1:0] res_busy
);
   AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid); // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid); // R2
   AST_ACQ_GROWS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && $past(cmd_op) == OP_ACQ) |->
      ($countones(res_busy) == $countones($past(res_busy)) + 1)); // R3
   AST_FAULT_KEEPS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (res_busy == $past(res_busy))); // R4
   AST_EXPORT_HW_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && !rsp_sw && $past(cmd_op) == OP_EXP) |->
      !rsp_data[0]); // R6
   AST_POOL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(res_busy) <= N_HANDLE); // R7
   AST_SW_REBIND_NO_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && rsp_sw && $past(cmd_op) == OP_REB) |->
      (res_busy == $past(res_busy))); // R8
   AST_CMD_SW_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_sw && $past(cmd_op) == OP_CMD) |-> rsp_fault); // R9
endmodule

bind eng_bind_table eng_bind_table_chk #(
   .N_HANDLE(N_HANDLE), .N_RESOURCE(N_RESOURCE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
   .rsp_sw(rsp_sw), .res_busy(res_busy)
);

// File: tb/eng_bind_table_test.sv
module eng_bind_table_test;
   localparam int CLK_PERIOD = 10;
   localparam int NH = 4;
   localparam int NR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [1:0]  cmd_handle = '0;
   logic [3:0]  cmd_type = '0;
   logic [31:0] cmd_data = '0;
   logic        rsp_valid, rsp_fault, rsp_sw;
   logic [31:0] rsp_data;
   logic [NR-1:0] res_busy;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   eng_bind_table uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_handle(cmd_handle), .cmd_type(cmd_type), .cmd_data(cmd_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
      .rsp_sw(rsp_sw), .res_busy(res_busy)
   );

   // reference model
   bit          m_bound [NH];
   bit          m_sw    [NH];
   logic [31:0] m_word  [NH];

   function automatic int rtype(int r);
      int t [NR] = '{0, 0, 1, 1, 1, 2, 3, 3};
      return t[r];
   endfunction

   function automatic bit m_busy(int r);
      for (int h = 0; h < NH; h++)
         if (m_bound[h] && !m_sw[h] && m_word[h] == 32'(r * 2)) return 1;
      return 0;
   endfunction

   function automatic logic [NR-1:0] m_busy_vec();
      logic [NR-1:0] v;
      for (int r = 0; r < NR; r++) v[r] = m_busy(r);
      return v;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model(input logic [2:0] op, input int h, input int ty,
                        input logic [31:0] d, output logic [31:0] ed,
                        output logic ef, output logic es, output string tag);
      ed = '0; ef = 0;
      case (op)
         3'd0: tag = "R2";
         3'd1: begin
            if (m_bound[h]) begin ef = 1; tag = "R10"; end
            else begin
               int pick = -1;
               for (int r = NR - 1; r >= 0; r--)
                  if (rtype(r) == ty && !m_busy(r)) pick = r;
               if (pick < 0) begin ef = 1; tag = "R4"; end
               else begin
                  tag = "R3";
                  m_bound[h] = 1; m_sw[h] = 0; m_word[h] = 32'(pick * 2);
                  ed = m_word[h];
               end
            end
         end
         3'd2: begin
            tag = "R5";
            if (!m_bound[h]) ef = 1;
            else begin m_bound[h] = 0; m_sw[h] = 0; m_word[h] = '0; end
         end
         3'd3: begin
            tag = "R6";
            if (!m_bound[h]) ef = 1; else ed = m_word[h];
         end
         3'd4: begin
            if (m_bound[h]) begin ef = 1; tag = "R10"; end
            else if (d[0]) begin
               tag = "R8";
               m_bound[h] = 1; m_sw[h] = 1; m_word[h] = d; ed = d;
            end else begin
               int idx = int'(d[31:1]);
               tag = "R7";
               if (d[31:1] >= 31'(NR) || rtype(idx) != ty || m_busy(idx)) ef = 1;
               else begin m_bound[h] = 1; m_sw[h] = 0; m_word[h] = d; ed = d; end
            end
         end
         3'd5: begin
            tag = "R9";
            if (!m_bound[h] || m_sw[h]) ef = 1; else ed = m_word[h];
         end
         default: begin ef = 1; tag = "R2"; end
      endcase
      es = m_bound[h] && m_sw[h];
   endtask

   // drive at a falling edge, sample the response at the next falling edge
   task automatic issue(input logic [2:0] op, input int h, input int ty, input logic [31:0] d);
      logic [31:0] ed;
      logic ef, es;
      string tag;
      cmd_valid = 1; cmd_op = op; cmd_handle = 2'(h); cmd_type = 4'(ty); cmd_data = d;
      model(op, h, ty, d, ed, ef, es, tag);
      @(negedge clk);
      cmd_valid = 0;
      check("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
      check(tag, "rsp_data", rsp_data, ed);
      check(tag, "rsp_fault", 32'(rsp_fault), 32'(ef));
      check(tag, "rsp_sw", 32'(rsp_sw), 32'(es));
      check(tag, "res_busy", 32'(res_busy), 32'(m_busy_vec()));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int h = 0; h < NH; h++) begin m_bound[h] = 0; m_sw[h] = 0; m_word[h] = '0; end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1", "res_busy", 32'(res_busy), 32'd0);
      @(negedge clk);
      check("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);

      issue(3'd5, 0, 0, 0);              // R9 unbound command
      issue(3'd1, 0, 1, 0);              // R3 -> index 2
      issue(3'd1, 1, 1, 0);              // R3 -> index 3
      issue(3'd1, 2, 1, 0);              // R3 -> index 4
      issue(3'd1, 3, 1, 0);              // R4 none left
      issue(3'd1, 0, 0, 0);              // R10 already bound
      issue(3'd3, 1, 0, 0);              // R6 export hw
      issue(3'd2, 1, 0, 0);              // R5 release
      issue(3'd2, 1, 0, 0);              // R5 release unbound
      issue(3'd3, 1, 0, 0);              // R6 export unbound
      issue(3'd4, 1, 1, 32'd6);          // R7 rebind ok
      issue(3'd4, 1, 1, 32'd6);          // R10 rebind bound
      issue(3'd2, 1, 0, 0);
      issue(3'd4, 1, 1, 32'd4);          // R7 busy elsewhere
      issue(3'd4, 1, 1, 32'd16);         // R7 out of range
      issue(3'd4, 1, 1, 32'd10);         // R7 type mismatch
      issue(3'd4, 1, 0, 32'hABCD_0001);  // R8 software binding
      issue(3'd3, 1, 0, 0);              // R6 export software
      issue(3'd5, 1, 0, 0);              // R9 software faults
      issue(3'd5, 0, 0, 0);              // R9 hardware ok
      issue(3'd2, 1, 0, 0);              // R5 release software
      issue(3'd7, 0, 0, 0);              // R2 illegal op
      issue(3'd0, 2, 0, 0);              // R2 no-op
      for (int h = 0; h < NH; h++) issue(3'd2, h, 0, 0);

      for (int i = 0; i < 600; i++) begin
         logic [2:0] op = 3'($urandom_range(0, 7));
         int h = $urandom_range(0, NH - 1);
         int ty = $urandom_range(0, 4);
         logic [31:0] d;
         if ($urandom_range(0, 3) == 0) d = $urandom;
         else d = 32'($urandom_range(0, 19));
         issue(op, h, ty, d);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule